// File: doc/BRIEF.md
# Four-Port Mailbox Interrupt Controller

This block generates the per-port interrupt flags for a memory that four ports share. The highest four addresses of the memory act as mailboxes, one per port. The block watches every port's write strobe, read strobe and address. When some other port writes a port's mailbox, that port's active-low interrupt goes low. It stays low until the owning port reads its own mailbox.

The memory array is not part of the block. Neither is any arbitration of simultaneous accesses to it. Only the address decoding and the flag set/clear logic live here.

Port count and address width are parameters. When the port count is a power of two, the decoder matches the upper address bits and uses the low bits as the mailbox index. Otherwise it compares the address against each mailbox address.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after its release, every bit of `irq_n` is high (deasserted).
- R2: The mailbox of port index i (0-based) is at address 2^ADDR_W − NUM_PORTS + i. With the default ADDR_W = 12, port 0 is at 0xFFC, port 1 at 0xFFD, port 2 at 0xFFE and port 3 at 0xFFF. Accesses to any other address have no effect on any flag.
- R3: A write by port j to the mailbox of port i, with j ≠ i, drives `irq_n[i]` low at the next rising clock edge.
- R4: A read by port i of its own mailbox returns `irq_n[i]` high at the next rising clock edge, unless R7 applies.
- R5: A port writing its own mailbox leaves its own flag unchanged.
- R6: A read of port i's mailbox by any other port does not release `irq_n[i]`.
- R7: If a foreign write sets a flag in the same cycle that its owner's read would clear it, the set wins and `irq_n[i]` is low after the edge.
- R8: In a cycle with neither a foreign write to nor an owner read of mailbox i, `irq_n[i]` keeps its value.
- R9: Writes in the same cycle to different mailboxes set each addressed flag independently, and they leave the other flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | NUM_PORTS | Write strobe, one bit per port |
| rd_en | input | NUM_PORTS | Read strobe, one bit per port |
| addr | input | NUM_PORTS*ADDR_W | Concatenated port addresses; port p uses bits [p*ADDR_W +: ADDR_W] |
| irq_n | output | NUM_PORTS | Active-low mailbox interrupt, one bit per port |

## Verification
The assertions assume that strobes and addresses are known values that hold steady around each rising clock edge. They also assume that a strobe counts only for the address presented in the same cycle. The bench honours this by changing every input on the falling edge, holding it through exactly one rising edge, and reading `irq_n` on the following falling edge. The assertions also assume that the reset is applied before the first edge; the bench starts with `rst_n` low for several cycles. Because the expected flag values are written out per scenario, the bench covers the priority of a set over a clear, and it places the address just below the mailbox window and addresses that alias the mailbox low bits, so that a faulty decode is seen at the outputs.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   // Address of the mailbox owned by port index idx (0-based):
   // the mailboxes occupy the top num_ports locations of the space.
   function automatic longint unsigned mbox_addr(input int addr_w,
                                                 input int num_ports,
                                                 input int idx);
      longint unsigned top;
      top = (longint'(1) << addr_w) - 1;
      return top - longint'(num_ports) + 1 + longint'(idx);
   endfunction

   // True when n is a nonzero power of two.
   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/mbx_addr_decode.sv
// Decodes one port's address into a per-mailbox hit vector.
module mbx_addr_decode #(
   parameter int NUM_PORTS = 4,
   parameter int ADDR_W    = 12
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_PORTS-1:0] hit
);
   localparam bit POW2  = mbx_pkg::is_pow2(NUM_PORTS);
   localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

   generate
      if (POW2) begin : g_window
         // Mailbox window is aligned: upper bits all ones, low bits index.
         localparam int UP_W = ADDR_W - IDX_W;
         logic             in_window;
         logic [IDX_W-1:0] slot;

         assign in_window = &addr[ADDR_W-1:IDX_W];
         assign slot      = addr[IDX_W-1:0];

         for (genvar m = 0; m < NUM_PORTS; m++) begin : g_slot
            assign hit[m] = in_window && (slot == IDX_W'(m));
         end
         if (UP_W < 1) begin : g_bad_window
            $error("mbx_addr_decode: no upper bits left for the window match");
         end
      end else begin : g_compare
         // Unaligned window: one comparator per mailbox.
         for (genvar m = 0; m < NUM_PORTS; m++) begin : g_slot
            localparam logic [ADDR_W-1:0] MB_ADDR =
               ADDR_W'(mbx_pkg::mbox_addr(ADDR_W, NUM_PORTS, m));
            assign hit[m] = (addr == MB_ADDR);
         end
      end
   endgenerate

endmodule

// File: rtl/mbx_req_matrix.sv
// Turns per-port decoded hits and strobes into per-mailbox set/clear requests.
module mbx_req_matrix #(
   parameter int NUM_PORTS = 4
) (
   input  logic [NUM_PORTS-1:0]                wr_en,
   input  logic [NUM_PORTS-1:0]                rd_en,
   input  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] hit,     // [accessing port][mailbox]
   output logic [NUM_PORTS-1:0]                set_req,
   output logic [NUM_PORTS-1:0]                clr_req
);
   generate
      for (genvar o = 0; o < NUM_PORTS; o++) begin : g_owner
         logic [NUM_PORTS-1:0] writer_hits;
         logic [NUM_PORTS-1:0] foreign_mask;

         // Every port except the owner may set the owner's flag.
         for (genvar j = 0; j < NUM_PORTS; j++) begin : g_writer
            assign foreign_mask[j] = (j != o);
            assign writer_hits[j]  = wr_en[j] && hit[j][o];
         end

         assign set_req[o] = |(writer_hits & foreign_mask);
         // Only the owner's read of its own mailbox clears.
         assign clr_req[o] = rd_en[o] && hit[o][o];
      end
   endgenerate

endmodule

// File: rtl/mbx_flag_cell.sv
// One registered interrupt flag; set has priority over clear.
module mbx_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic irq_n
);
   logic pending_q;
   logic pending_d;

   always_comb begin
      pending_d = pending_q;
      if (set_req) begin
         pending_d = 1'b1;
      end else if (clr_req) begin
         pending_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
      end else begin
         pending_q <= pending_d;
      end
   end

   assign irq_n = ~pending_q;

endmodule

// File: rtl/mbx_irq_ctrl.sv
// Mailbox interrupt controller for a multi-port shared memory.
module mbx_irq_ctrl #(
   parameter int NUM_PORTS = 4,
   parameter int ADDR_W    = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_PORTS-1:0]          wr_en,
   input  logic [NUM_PORTS-1:0]          rd_en,
   input  logic [NUM_PORTS*ADDR_W-1:0]   addr,
   output logic [NUM_PORTS-1:0]          irq_n
);
   localparam longint unsigned SPACE = longint'(1) << ADDR_W;

   // Elaboration-time parameter checks.
   generate
      if (NUM_PORTS < 2) begin : g_bad_ports
         $error("mbx_irq_ctrl: NUM_PORTS must be at least 2");
      end
      if (ADDR_W < 2 || ADDR_W > 40) begin : g_bad_width
         $error("mbx_irq_ctrl: ADDR_W must lie in 2..40");
      end
      if (longint'(NUM_PORTS) >= SPACE) begin : g_bad_space
         $error("mbx_irq_ctrl: mailboxes must leave room for ordinary memory");
      end
   endgenerate

   logic [NUM_PORTS-1:0][NUM_PORTS-1:0] hit;
   logic [NUM_PORTS-1:0]                set_req;
   logic [NUM_PORTS-1:0]                clr_req;

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         mbx_addr_decode #(
            .NUM_PORTS (NUM_PORTS),
            .ADDR_W    (ADDR_W)
         ) u_dec (
            .addr (addr[p*ADDR_W +: ADDR_W]),
            .hit  (hit[p])
         );

         mbx_flag_cell u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (set_req[p]),
            .clr_req (clr_req[p]),
            .irq_n   (irq_n[p])
         );
      end
   endgenerate

   mbx_req_matrix #(
      .NUM_PORTS (NUM_PORTS)
   ) u_req (
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .hit     (hit),
      .set_req (set_req),
      .clr_req (clr_req)
   );

endmodule

// File: rtl/mbx_irq_checker.sv
// Protocol checker for mbx_irq_ctrl, attached by bind.
module mbx_irq_checker #(
   parameter int NUM_PORTS = 4,
   parameter int ADDR_W    = 12
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_PORTS-1:0]        wr_en,
   input logic [NUM_PORTS-1:0]        rd_en,
   input logic [NUM_PORTS*ADDR_W-1:0] addr,
   input logic [NUM_PORTS-1:0]        irq_n
);
   logic [NUM_PORTS-1:0] foreign_wr;
   logic [NUM_PORTS-1:0] owner_rd;
   logic [NUM_PORTS-1:0] self_wr;

   always_comb begin
      foreign_wr = '0;
      owner_rd   = '0;
      self_wr    = '0;
      for (int i = 0; i < NUM_PORTS; i++) begin
         for (int j = 0; j < NUM_PORTS; j++) begin
            if (j != i && wr_en[j] &&
                addr[j*ADDR_W +: ADDR_W] == ADDR_W'(mbx_pkg::mbox_addr(ADDR_W, NUM_PORTS, i)))
               foreign_wr[i] = 1'b1;
         end
         owner_rd[i] = rd_en[i] &&
            (addr[i*ADDR_W +: ADDR_W] == ADDR_W'(mbx_pkg::mbox_addr(ADDR_W, NUM_PORTS, i)));
         self_wr[i]  = wr_en[i] &&
            (addr[i*ADDR_W +: ADDR_W] == ADDR_W'(mbx_pkg::mbox_addr(ADDR_W, NUM_PORTS, i)));
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_IDLE: assert (irq_n == '1); // R1
      end
   end

   generate
      for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
         AST_FOREIGN_SET: assert property (@(posedge clk) disable iff (!rst_n)
            foreign_wr[i] |=> !irq_n[i]); // R3
         AST_OWNER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            owner_rd[i] && !foreign_wr[i] |=> irq_n[i]); // R4
         AST_SELF_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
            self_wr[i] && !foreign_wr[i] && !owner_rd[i] |=> $stable(irq_n[i])); // R5
         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            foreign_wr[i] && owner_rd[i] |=> !irq_n[i]); // R7
         AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !foreign_wr[i] && !owner_rd[i] |=> $stable(irq_n[i])); // R8
      end
   endgenerate

endmodule

bind mbx_irq_ctrl mbx_irq_checker #(
   .NUM_PORTS (NUM_PORTS),
   .ADDR_W    (ADDR_W)
) u_mbx_irq_checker (
   .clk   (clk),
   .rst_n (rst_n),
   .wr_en (wr_en),
   .rd_en (rd_en),
   .addr  (addr),
   .irq_n (irq_n)
);

// File: tb/tb_mbx_irq_ctrl.sv
module tb_mbx_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 4;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] wr_en = '0;
   logic [NP-1:0] rd_en = '0;
   logic [NP*AW-1:0] addr = '0;
   logic [NP-1:0] irq_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   mbx_irq_ctrl #(.NUM_PORTS(NP), .ADDR_W(AW)) dut (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en),
      .rd_en (rd_en), .addr (addr), .irq_n (irq_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Mailbox addresses from R2: 0xFFC + port index.
   localparam logic [AW-1:0] MB0 = 12'hFFC;
   localparam logic [AW-1:0] MB1 = 12'hFFD;
   localparam logic [AW-1:0] MB2 = 12'hFFE;
   localparam logic [AW-1:0] MB3 = 12'hFFF;

   task automatic check(input logic [NP-1:0] exp, input string req);
      checks++;
      if (irq_n !== exp) begin
         fails++;
         $display("FAIL %s: irq_n=%b expected %b", req, irq_n, exp);
      end
   endtask

   // Drive one access cycle at a falling edge, hold it through one rising
   // edge, remove it at the next falling edge (where outputs are read).
   task automatic cycle(input logic [NP-1:0] w, input logic [NP-1:0] r,
                        input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                        input logic [AW-1:0] a2, input logic [AW-1:0] a3);
      @(negedge clk);
      wr_en = w; rd_en = r; addr = {a3, a2, a1, a0};
      @(negedge clk);
      wr_en = '0; rd_en = '0; addr = '0;
   endtask

   task automatic t_reset();
      check(4'b1111, "R1 during reset");
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check(4'b1111, "R1 after release");
   endtask

   task automatic t_foreign_set();
      cycle(4'b0010, 4'b0000, 0, MB0, 0, 0);           // port1 writes mailbox 0
      check(4'b1110, "R3 foreign write sets");
   endtask

   task automatic t_other_read();
      cycle(4'b0000, 4'b0110, 0, MB0, MB0, 0);         // ports 1,2 read mailbox 0
      check(4'b1110, "R6 non-owner read keeps flag");
   endtask

   task automatic t_owner_clear();
      cycle(4'b0000, 4'b0001, MB0, 0, 0, 0);           // port0 reads own mailbox
      check(4'b1111, "R4 owner read clears");
   endtask

   task automatic t_self_write();
      cycle(4'b1000, 4'b0000, 0, 0, 0, MB3);           // port3 writes own mailbox
      check(4'b1111, "R5 self write ignored");
   endtask

   task automatic t_non_mailbox();
      // Just below the window, address zero, and an alias of MB1 low bits.
      cycle(4'b0111, 4'b0000, 12'hFFB, 12'h000, 12'h7FD, 0);
      check(4'b1111, "R2 non-mailbox writes ignored");
   endtask

   task automatic t_multi_and_hold();
      cycle(4'b0111, 4'b0000, MB1, MB2, MB3, 0);       // sets flags 1,2,3
      check(4'b0001, "R9 simultaneous writes");
      @(negedge clk);
      check(4'b0001, "R8 idle hold");
      cycle(4'b1000, 4'b0000, 0, 0, 0, MB0);           // port3 sets flag 0
      check(4'b0000, "R9 independent set");
      cycle(4'b0000, 4'b0010, 0, MB2, 0, 0);           // port1 reads mailbox 2
      check(4'b0000, "R6 wrong mailbox read");
   endtask

   task automatic t_set_wins();
      cycle(4'b0001, 4'b0100, MB2, 0, MB2, 0);         // set and clear of flag 2
      check(4'b0000, "R7 set wins on pending flag");
      cycle(4'b0000, 4'b1111, MB0, MB1, MB2, MB3);     // all owners read
      check(4'b1111, "R4 all owners clear");
      cycle(4'b1000, 4'b0010, 0, MB1, 0, MB1);         // clear+set of idle flag 1
      check(4'b1101, "R7 set wins on idle flag");
      cycle(4'b0000, 4'b0010, 0, MB1, 0, 0);
      check(4'b1111, "R4 clear after collision");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_foreign_set();
      t_other_read();
      t_owner_clear();
      t_self_write();
      t_non_mailbox();
      t_multi_and_hold();
      t_set_wins();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule